// File: doc/BRIEF.md
# Program-Space Data Window Controller

This block lets ordinary data reads that land in the upper half of a 16-bit data address map be served from a selectable page of program memory. The CPU presents each read's effective address with a strobe. The block then decides whether the read goes to the program-space window or to normal data RAM. For a window read, it forms the program-memory word address from an 8-bit page register and the low 15 address bits. It then issues a request on a synchronous request/acknowledge port and returns the low 16 bits of the 24-bit program word.

While the fetch is in flight, the block drives a stall output that holds the CPU pipeline. The number of held cycles is set by a 2-bit instruction-class code and by the read's place in a hardware REPEAT loop. A slow memory acknowledge stretches the stall. Window access is blocked while a table read or table write is active. The page and the enable bit sit in registers written through a small configuration port.

Top module: `pgw_top`

## Requirements
- R1: A read request (`rd_req`) is a window hit only when `rd_addr[15]` is 1, the visibility enable is set and `tbl_busy` is 0. A hit raises `pm_req` one cycle after the request edge. Any other request raises no `pm_req` and instead pulses `dram_sel` for one cycle, one cycle after the request edge.
- R2: The fetch address is `pm_addr = {page, rd_addr[14:0]}`, with the page in the upper 8 bits. `pm_req` and `pm_addr` hold steady until the edge at which `pm_ack` is sampled high, and `pm_req` drops after that edge.
- R3: The returned `rd_data` equals bits [15:0] of the `pm_rdata` word that was present with the acknowledge. Bits [23:16] are dropped.
- R4: Outside a REPEAT loop (`in_repeat`=0), class codes 0 (MAC with operand prefetch), 1 (MOV) and 2 (double MOV) cost N=1 extra cycle. Class code 3 (all others) costs N=2.
- R5: Inside a REPEAT loop, N=2 when any of `first_iter`, `last_iter`, `irq_exit` or `irq_reentry` is set.
- R6: Inside a REPEAT loop with none of those four flags set, N=0: no stall in the cycle after the request edge, and with a one-cycle acknowledge no stall at all.
- R7: While `tbl_busy` is 1, a request at an address of 0x8000 or above raises no `pm_req` and no stall.
- R8: With the acknowledge sampled at edge A after the request edge (A>=1), `rd_valid` pulses for one cycle after edge max(N,A). `stall` is high in exactly max(N,A) cycles when N>=1, and in max(N,A)-1 cycles when N=0. `stall` is low while `rd_valid` is high.
- R9: A configuration write during an outstanding fetch does not change that fetch's address. The write applies from the next request on.
- R10: After reset, `stall`, `rd_valid`, `pm_req` and `dram_sel` are 0. The window is disabled and the page is 0.
- R11: A request that arrives while a fetch is outstanding starts no new fetch and leaves `pm_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_page | input | 8 | Page value to write |
| cfg_vis_en | input | 1 | Window enable value to write |
| rd_req | input | 1 | Data read request |
| rd_addr | input | 16 | Data effective address |
| rd_class | input | 2 | Instruction class: 0 MAC-prefetch, 1 MOV, 2 double MOV, 3 other |
| in_repeat | input | 1 | Read issued inside a REPEAT loop |
| first_iter | input | 1 | First loop iteration |
| last_iter | input | 1 | Last loop iteration |
| irq_exit | input | 1 | Iteration left for an interrupt |
| irq_reentry | input | 1 | First iteration after the interrupt returns |
| tbl_busy | input | 1 | Table read/write in progress |
| stall | output | 1 | Pipeline hold |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data from program space |
| dram_sel | output | 1 | Read routed to data RAM |
| pm_req | output | 1 | Program memory request |
| pm_addr | output | 23 | Program memory word address |
| pm_ack | input | 1 | Program memory acknowledge |
| pm_rdata | input | 24 | Program memory word |

## Verification
Assertions check on every cycle that a fetch only starts from a qualifying request, that no fetch starts under a table operation, and that the request and address hold until acknowledged. They also check that the stall covers every outstanding penalty cycle and that the valid pulse is single and stall-free. The exact stall lengths per class and loop position, their stretch under slow acknowledges, the data and address mapping, and the delayed effect of configuration writes are shown only by the bench's sweeps. Those sweeps run over every class, every loop-flag combination and several memory latencies.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    CLS_MAC_PF = 2'd0,
    CLS_MOV    = 2'd1,
    CLS_MOVD   = 2'd2,
    CLS_OTHER  = 2'd3
  } op_class_e;

  typedef struct packed {
    logic in_rep;
    logic first;
    logic last;
    logic irq_exit;
    logic irq_back;
  } loop_ctx_t;
endpackage

// File: rtl/pgw_decode.sv
module pgw_decode #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  localparam int OFS_W = ADDR_W - 1,
  localparam int PM_AW = PAGE_W + OFS_W
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] ea,
  input  logic [PAGE_W-1:0] page,
  input  logic              vis_en,
  input  logic              tbl_busy,
  output logic              hit,
  output logic              miss,
  output logic [PM_AW-1:0]  word_addr
);
  logic in_window;

  always_comb begin
    in_window = ea[ADDR_W-1] && vis_en && !tbl_busy;
    hit       = req && in_window;
    miss      = req && !in_window;
    word_addr = {page, ea[OFS_W-1:0]};
  end
endmodule

// File: rtl/pgw_penalty.sv
module pgw_penalty
  import pgw_pkg::*;
#(
  parameter int EXTRA_SHORT = 1,
  parameter int EXTRA_LONG  = 2,
  localparam int CNT_W = $clog2(EXTRA_LONG + 1)
) (
  input  op_class_e        cls,
  input  loop_ctx_t        ctx,
  output logic [CNT_W-1:0] extra
);
  logic edge_iter;

  always_comb begin
    edge_iter = ctx.first || ctx.last || ctx.irq_exit || ctx.irq_back;
    if (ctx.in_rep) begin
      extra = edge_iter ? CNT_W'(EXTRA_LONG) : '0;
    end else begin
      unique case (cls)
        CLS_MAC_PF, CLS_MOV, CLS_MOVD: extra = CNT_W'(EXTRA_SHORT);
        default:                       extra = CNT_W'(EXTRA_LONG);
      endcase
    end
  end
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq #(
  parameter int CNT_W  = 2,
  parameter int PM_AW  = 23,
  parameter int WORD_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PM_AW-1:0]  start_addr,
  input  logic [CNT_W-1:0]  start_extra,
  input  logic              pm_ack,
  input  logic [WORD_W-1:0] pm_rdata,
  output logic              pm_req,
  output logic [PM_AW-1:0]  pm_addr,
  output logic              stall,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             got, got_n, done_n, take;

  always_comb begin
    take   = pm_req && pm_ack;
    got_n  = got || take;
    cnt_n  = (cnt == '0) ? '0 : cnt - 1'b1;
    done_n = got_n && (cnt_n == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      pm_req   <= 1'b0;
      pm_addr  <= '0;
      stall    <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      cnt      <= '0;
      got      <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          pm_req  <= 1'b1;
          pm_addr <= start_addr;
          cnt     <= start_extra;
          got     <= 1'b0;
          stall   <= (start_extra != '0);
        end else begin
          stall <= 1'b0;
        end
      end else begin
        if (take) begin
          pm_req  <= 1'b0;
          rd_data <= pm_rdata[DATA_W-1:0];
        end
        cnt <= cnt_n;
        got <= got_n;
        if (done_n) begin
          busy     <= 1'b0;
          rd_valid <= 1'b1;
          stall    <= 1'b0;
        end else begin
          stall <= 1'b1;
        end
      end
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    pm_req && !pm_ack |=> pm_req && $stable(pm_addr));

  assert_penalty_stall_R4: assert property (@(posedge clk) disable iff (rst)
    busy && (cnt != '0) |-> stall);

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  assert_valid_free_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !stall);
endmodule

// File: rtl/pgw_top.sv
module pgw_top
  import pgw_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_W      = 8,
  parameter int WORD_W      = 24,
  parameter int DATA_W      = 16,
  parameter int EXTRA_SHORT = 1,
  parameter int EXTRA_LONG  = 2,
  localparam int PM_AW = PAGE_W + ADDR_W - 1,
  localparam int CNT_W = $clog2(EXTRA_LONG + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic              cfg_vis_en,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        rd_class,
  input  logic              in_repeat,
  input  logic              first_iter,
  input  logic              last_iter,
  input  logic              irq_exit,
  input  logic              irq_reentry,
  input  logic              tbl_busy,
  output logic              stall,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              dram_sel,
  output logic              pm_req,
  output logic [PM_AW-1:0]  pm_addr,
  input  logic              pm_ack,
  input  logic [WORD_W-1:0] pm_rdata
);
  logic [PAGE_W-1:0] page_q;
  logic              vis_q;
  logic              hit, miss, busy;
  logic [PM_AW-1:0]  word_addr;
  logic [CNT_W-1:0]  extra;
  loop_ctx_t         ctx;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q   <= '0;
      vis_q    <= 1'b0;
      dram_sel <= 1'b0;
    end else begin
      if (cfg_we) begin
        page_q <= cfg_page;
        vis_q  <= cfg_vis_en;
      end
      dram_sel <= miss;
    end
  end

  always_comb begin
    ctx = '{in_rep: in_repeat, first: first_iter, last: last_iter,
            irq_exit: irq_exit, irq_back: irq_reentry};
  end

  pgw_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_decode (
    .req(rd_req), .ea(rd_addr), .page(page_q), .vis_en(vis_q),
    .tbl_busy(tbl_busy), .hit(hit), .miss(miss), .word_addr(word_addr)
  );

  pgw_penalty #(.EXTRA_SHORT(EXTRA_SHORT), .EXTRA_LONG(EXTRA_LONG)) u_penalty (
    .cls(op_class_e'(rd_class)), .ctx(ctx), .extra(extra)
  );

  pgw_seq #(.CNT_W(CNT_W), .PM_AW(PM_AW), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .start(hit), .start_addr(word_addr),
    .start_extra(extra), .pm_ack(pm_ack), .pm_rdata(pm_rdata),
    .pm_req(pm_req), .pm_addr(pm_addr), .stall(stall),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy)
  );

  assert_fetch_gate_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(pm_req) |-> $past(rd_req && rd_addr[ADDR_W-1] && vis_q && !tbl_busy));

  assert_tbl_block_R7: assert property (@(posedge clk) disable iff (rst)
    rd_req && tbl_busy && !busy |=> !pm_req);

  assert_route_excl_R1: assert property (@(posedge clk) disable iff (rst)
    dram_sel |-> !$rose(pm_req));
endmodule

// File: tb/pgw_top_tb.sv
module pgw_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 0, cfg_vis_en = 0;
  logic [7:0]  cfg_page = 0;
  logic        rd_req = 0;
  logic [15:0] rd_addr = 0;
  logic [1:0]  rd_class = 0;
  logic        in_repeat = 0, first_iter = 0, last_iter = 0, irq_exit = 0, irq_reentry = 0;
  logic        tbl_busy = 0;
  logic        stall, rd_valid, dram_sel, pm_req;
  logic [15:0] rd_data;
  logic [22:0] pm_addr;
  logic        pm_ack = 0;
  logic [23:0] pm_rdata = 0;

  int n_cmp = 0, n_bad = 0;
  int mem_lat = 1, mcnt = 0;
  logic [7:0] m_page = 0;
  logic       m_en = 0;

  always #2.5 clk = ~clk;

  pgw_top u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_page(cfg_page), .cfg_vis_en(cfg_vis_en),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_class(rd_class), .in_repeat(in_repeat),
    .first_iter(first_iter), .last_iter(last_iter), .irq_exit(irq_exit),
    .irq_reentry(irq_reentry), .tbl_busy(tbl_busy), .stall(stall), .rd_valid(rd_valid),
    .rd_data(rd_data), .dram_sel(dram_sel), .pm_req(pm_req), .pm_addr(pm_addr),
    .pm_ack(pm_ack), .pm_rdata(pm_rdata)
  );

  function automatic logic [23:0] mem_word(input logic [22:0] a);
    return {a[22:15], a[15:0] ^ 16'hC3A5};
  endfunction

  always @(negedge clk) begin
    if (pm_req && !pm_ack) begin
      mcnt = mcnt + 1;
      if (mcnt >= mem_lat) begin
        pm_ack   <= 1'b1;
        pm_rdata <= mem_word(pm_addr);
      end
    end else begin
      pm_ack <= 1'b0;
      mcnt = 0;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] pg, input logic en);
    @(negedge clk);
    cfg_we = 1; cfg_page = pg; cfg_vis_en = en;
    @(negedge clk);
    cfg_we = 0;
    m_page = pg; m_en = en;
  endtask

  task automatic access(input logic [15:0] ea, input int cls, input bit rep,
                        input logic [3:0] fl, input bit tbl, input int lat);
    int n, v, exp_st, st_cnt, vj;
    bit hit;
    logic [22:0] ea_exp;
    logic [15:0] dat;
    string tg;
    hit = ea[15] && m_en && !tbl;
    if (rep) n = (fl != 0) ? 2 : 0;
    else n = (cls == 3) ? 2 : 1;
    tg = rep ? ((fl != 0) ? "R5" : "R6") : "R4";
    ea_exp = {m_page, ea[14:0]};
    @(negedge clk);
    mem_lat = lat;
    rd_req = 1; rd_addr = ea; rd_class = 2'(cls); in_repeat = rep;
    {first_iter, last_iter, irq_exit, irq_reentry} = fl; tbl_busy = tbl;
    @(negedge clk);
    rd_req = 0; tbl_busy = 0;
    if (!hit) begin
      check(pm_req == 0, tbl ? "R7" : "R1", pm_req, 0);
      check(dram_sel == 1, "R1", dram_sel, 1);
      check(stall == 0, tbl ? "R7" : "R1", stall, 0);
      @(negedge clk);
      check(pm_req == 0 && stall == 0, tbl ? "R7" : "R1", {pm_req, stall}, 0);
      return;
    end
    check(pm_req == 1 && dram_sel == 0, "R1", {pm_req, dram_sel}, 2);
    check(pm_addr == ea_exp, "R2", pm_addr, ea_exp);
    check(stall == (n != 0), tg, stall, n != 0);
    v = (n > lat) ? n : lat;
    exp_st = v - ((n == 0) ? 1 : 0);
    st_cnt = 0; vj = -1; dat = 0;
    for (int j = 0; j < 20; j++) begin
      if (j > 0) @(negedge clk);
      if (stall) st_cnt++;
      if (rd_valid) begin vj = j; dat = rd_data; break; end
    end
    check(vj == v, (lat > n) ? "R8" : tg, vj, v);
    check(st_cnt == exp_st, (lat > n) ? "R8" : tg, st_cnt, exp_st);
    check(dat == (ea_exp[15:0] ^ 16'hC3A5), "R3", dat, ea_exp[15:0] ^ 16'hC3A5);
    @(negedge clk);
    check(pm_req == 0 && stall == 0, "R2", {pm_req, stall}, 0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    check(stall == 0 && rd_valid == 0 && pm_req == 0 && dram_sel == 0, "R10",
          {stall, rd_valid, pm_req, dram_sel}, 0);
    access(16'h9234, 0, 0, 4'h0, 0, 1);  // R10: window disabled after reset
    // R1 misses
    cfg_write(8'h5A, 1);
    access(16'h1234, 3, 0, 4'h0, 0, 1);
    access(16'h7FFF, 1, 0, 4'h0, 0, 1);
    // R7 table suppression
    access(16'h8000, 1, 0, 4'h0, 1, 1);
    access(16'hFFFF, 3, 1, 4'h1, 1, 2);
    // sweep: class x loop flags x latency
    for (int lat = 1; lat <= 3; lat++) begin
      for (int rep = 0; rep < 2; rep++) begin
        for (int fl = 0; fl < 16; fl++) begin
          for (int cls = 0; cls < 4; cls++) begin
            logic [15:0] ea;
            ea = 16'h8000 | 16'((lat * 977 + fl * 131 + cls * 4099 + rep * 7) & 16'h7FFF);
            if (rep == 0 && fl != 0) continue;
            access(ea, cls, rep[0], 4'(fl), 0, lat);
          end
        end
      end
      cfg_write(8'(8'h5A + lat * 37), 1);
    end
    access(16'h8000, 2, 0, 4'h0, 0, 1);
    access(16'hFFFF, 0, 1, 4'h0, 0, 1);
    // R9: config write during outstanding fetch
    begin
      logic [22:0] old_a;
      cfg_write(8'h11, 1);
      old_a = {8'h11, 15'h0ABC};
      @(negedge clk);
      mem_lat = 3; rd_req = 1; rd_addr = 16'h8ABC; rd_class = 3; in_repeat = 0;
      {first_iter, last_iter, irq_exit, irq_reentry} = 4'h0;
      @(negedge clk);
      rd_req = 0; cfg_we = 1; cfg_page = 8'hEE; cfg_vis_en = 1;
      @(negedge clk);
      cfg_we = 0; m_page = 8'hEE;
      check(pm_addr == old_a, "R9", pm_addr, old_a);
      repeat (4) @(negedge clk);
      access(16'h8ABC, 1, 0, 4'h0, 0, 1);  // R9: new page applies
    end
    // R11: request during outstanding fetch ignored
    begin
      logic [22:0] a0;
      a0 = {8'hEE, 15'h0123};
      @(negedge clk);
      mem_lat = 3; rd_req = 1; rd_addr = 16'h8123; rd_class = 3;
      @(negedge clk);
      rd_addr = 16'hC456;
      @(negedge clk);
      rd_req = 0;
      check(pm_addr == a0, "R11", pm_addr, a0);
      repeat (3) @(negedge clk);
      check(pm_req == 0 && stall == 0, "R11", {pm_req, stall}, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule